// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This block sits between a processor core and a 32-bit word-addressed data memory and handles every byte-lane detail of a memory access. On the request side it adds a sign-extended 16-bit offset to a base register, splits the sum into a word address and a byte offset, and for stores produces a 4-bit byte-enable mask together with write data already moved onto the right lanes. On the return side it takes the word read from memory, the byte offset of the access and the old value of the destination register, and forms the value to write back.

Byte, halfword and word accesses are supported, with signed or unsigned extension on loads. Two partial-word forms, "upper" and "lower", let software read or write an unaligned word in two steps. Each step merges part of a memory word into part of a register, or writes part of a word with a partial byte-enable mask. Memory is little-endian: byte lane n of a word holds the byte whose address bits [1:0] equal n. A halfword with address bit 0 set, or a word with a non-zero byte offset, is flagged as misaligned and performs no memory access.

Both sides are registered. Request outputs appear one clock after `req_valid`. The load result appears one clock after `ld_valid`. The two sides are independent, so a new request and the completion of an earlier load can be handled in the same cycle.

Top module: `lsa_top`

## Requirements
- R1: For an accepted request, `mem_addr` equals bits [31:2] of `req_base` plus `req_imm` sign-extended to 32 bits. It appears on the clock edge after `req_valid` and wraps modulo 2^32.
- R2: A byte store (`req_kind` 0) at byte offset k sets only bit k of `mem_be`. It places `req_wdata[7:0]` on bits [8k+7:8k] of `mem_wdata` and drives zero on every other lane.
- R3: A halfword store (`req_kind` 1) at offset 0 sets `mem_be` to 4'b0011 and places `req_wdata[15:0]` on bits [15:0]. At offset 2 it sets 4'b1100 and places it on bits [31:16]. Other lanes are zero.
- R4: A word access (`req_kind` 2) at offset 0 sets `mem_be` to 4'b1111; a word store drives `req_wdata` unchanged.
- R5: An upper-part store (`req_kind` 3) at offset k enables lanes 0..k and places register bytes 3-k..3 on lanes 0..k. A lower-part store (`req_kind` 4) at offset k enables lanes k..3 and places register bytes 0..3-k on lanes k..3.
- R6: A byte load (`ld_kind` 0) returns memory lane `ld_off`. It is sign-extended when `ld_unsigned` is 0 and zero-extended when `ld_unsigned` is 1.
- R7: A halfword load (`ld_kind` 1) returns lanes 0..1 when `ld_off[1]` is 0 and lanes 2..3 otherwise. It is sign-extended when `ld_unsigned` is 0 and zero-extended when `ld_unsigned` is 1.
- R8: An upper-part load (`ld_kind` 3) at offset k replaces register bytes 3-k..3 with memory lanes 0..k. A lower-part load (`ld_kind` 4) at offset k replaces register bytes 0..3-k with memory lanes k..3. All other bytes keep their value from `ld_old`.
- R9: A halfword request with address bit 0 set, or a word request with non-zero address bits [1:0], raises `align_err` for one cycle. In that cycle `mem_we` and `mem_re` are 0 and `mem_be` is 0. Partial-word and byte kinds never raise the flag.
- R10: `mem_we` rises only for stores and `mem_re` only for loads, never both together. Reserved kinds 5..7 raise neither enable nor `align_err`, leave `mem_be` at 0, and return `ld_old` unchanged as the load result. Reset clears every output to 0.
- R11: `ld_done` is high exactly one clock after `ld_valid`, and a word load returns the memory word unchanged. `ld_result` holds its value while `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access kind: 0 byte, 1 half, 2 word, 3 upper part, 4 lower part |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| align_err | output | 1 | Misaligned request flag |
| ld_valid | input | 1 | Memory word for a load is present |
| ld_kind | input | 3 | Kind of the completing load |
| ld_unsigned | input | 1 | Zero-extend instead of sign-extend |
| ld_off | input | 2 | Byte offset of the load address |
| ld_rdata | input | 32 | Word returned by memory |
| ld_old | input | 32 | Current destination register value |
| ld_result | output | 32 | Value to write back |
| ld_done | output | 1 | Result valid strobe |

## Verification
The hardest case to reach from the ports is a partial-word merge in which every byte of the result can be traced to its source. This needs all four offsets, with the old register bytes distinct from the memory bytes. Directed cases cover those offsets with easily told apart byte patterns. Random stimulus, with a fixed seed, varies kind, offset, extension and data on every cycle. A second hard case is a misaligned access reached through a negative offset that borrows across the word boundary. The bench reaches it by biasing the random base so that the computed address lands on a chosen low-bit pattern, and by running directed requests whose negative offsets wrap below zero.

// File: rtl/lsa_pkg.sv
// Shared constants and the access-kind encoding for the load-store
// alignment unit. Assumes a word of a power-of-two number of bytes.
package lsa_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ACC_BYTE  = 3'd0,
        ACC_HALF  = 3'd1,
        ACC_WORD  = 3'd2,
        ACC_UPPER = 3'd3,
        ACC_LOWER = 3'd4
    } acc_kind_e;
endpackage

// File: rtl/lsa_addr_gen.sv
// Effective-address adder and alignment classifier.
// Adds the sign-extended offset to the base and flags halfword and word
// accesses whose low address bits are not naturally aligned. Kinds above
// the last defined one are reported as not legal. Purely combinational.
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    input  logic [2:0]        kind,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned,
    output logic              legal
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    // Base plus sign-extended offset, wrapping at the address width.
    always_comb begin
        ea = base + {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Classify the kind and test natural alignment for half and word.
    always_comb begin
        legal      = (kind <= 3'(ACC_LOWER));
        misaligned = 1'b0;
        case (acc_kind_e'(kind))
            ACC_HALF: misaligned = ea[0];
            ACC_WORD: misaligned = |ea[OFF_W-1:0];
            default:  misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsa_store_lane.sv
// Store-side lane steering.
// From the access kind and byte offset, builds the byte-enable mask and
// moves the register bytes onto their memory lanes. Byte lane n holds
// the byte at offset n (little-endian). Lanes that are not enabled carry
// zero. Reserved kinds enable nothing. Purely combinational.
module lsa_store_lane
    import lsa_pkg::*;
(
    input  logic [2:0]        kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wdata
);
    localparam logic [LANES-1:0] ALL_LANES = '1;

    logic [OFF_W-1:0] inv_off;
    logic [OFF_W-1:0] half_off;

    // Distance from the top lane, and the lane base of a halfword.
    always_comb begin
        inv_off  = ~off;
        half_off = {off[OFF_W-1:1], 1'b0};
    end

    // Select mask and lane placement for each access kind.
    always_comb begin
        be    = '0;
        wdata = '0;
        case (acc_kind_e'(kind))
            ACC_BYTE: begin
                be    = LANES'(1) << off;
                wdata = WORD_W'(src[7:0]) << {off, 3'b000};
            end
            ACC_HALF: begin
                be    = LANES'(3) << half_off;
                wdata = WORD_W'(src[15:0]) << {half_off, 3'b000};
            end
            ACC_WORD: begin
                be    = ALL_LANES;
                wdata = src;
            end
            ACC_UPPER: begin
                be    = ALL_LANES >> inv_off;
                wdata = src >> {inv_off, 3'b000};
            end
            ACC_LOWER: begin
                be    = ALL_LANES << off;
                wdata = src << {off, 3'b000};
            end
            default: begin
                be    = '0;
                wdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsa_load_merge.sv
// Load-side extraction and merge.
// Picks the addressed byte or halfword out of the returned word and
// extends it, or merges part of the word into the old register value
// for the upper- and lower-part forms. Reserved kinds return the old
// value. Purely combinational.
module lsa_load_merge
    import lsa_pkg::*;
(
    input  logic [2:0]        kind,
    input  logic              zero_ext,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] old,
    output logic [WORD_W-1:0] result
);
    localparam logic [LANES-1:0] ALL_LANES = '1;

    logic [OFF_W-1:0]  inv_off;
    logic [OFF_W-1:0]  half_off;
    logic [WORD_W-1:0] byte_word;
    logic [WORD_W-1:0] half_word;
    logic [WORD_W-1:0] shifted;
    logic [LANES-1:0]  take_mem;
    logic [WORD_W-1:0] merged;
    logic              byte_sign;
    logic              half_sign;

    // Offsets and the selected byte / halfword brought down to lane 0.
    always_comb begin
        inv_off   = ~off;
        half_off  = {off[OFF_W-1:1], 1'b0};
        byte_word = rdata >> {off, 3'b000};
        half_word = rdata >> {half_off, 3'b000};
        byte_sign = ~zero_ext & byte_word[7];
        half_sign = ~zero_ext & half_word[15];
    end

    // Partial-word alignment: shifted memory word and lanes it replaces.
    always_comb begin
        if (acc_kind_e'(kind) == ACC_UPPER) begin
            shifted  = rdata << {inv_off, 3'b000};
            take_mem = ALL_LANES << inv_off;
        end else begin
            shifted  = rdata >> {off, 3'b000};
            take_mem = ALL_LANES >> off;
        end
    end

    // Per-lane choice between memory byte and old register byte.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = take_mem[i] ? shifted[8*i +: 8] : old[8*i +: 8];
    end

    // Final result per access kind.
    always_comb begin
        case (acc_kind_e'(kind))
            ACC_BYTE:  result = {{(WORD_W-8){byte_sign}}, byte_word[7:0]};
            ACC_HALF:  result = {{(WORD_W-16){half_sign}}, half_word[15:0]};
            ACC_WORD:  result = rdata;
            ACC_UPPER: result = merged;
            ACC_LOWER: result = merged;
            default:   result = old;
        endcase
    end
endmodule

// File: rtl/lsa_top.sv
// Load-store data alignment unit, top level.
// Request side: effective address, alignment check and store lane
// steering, registered one cycle. Load side: extraction and merge of
// the returned word, registered one cycle. The two sides are
// independent. Assumes memory is little-endian and word addressed.
module lsa_top
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_store,
    input  logic [2:0]              req_kind,
    input  logic [ADDR_W-1:0]       req_base,
    input  logic [IMM_W-1:0]        req_imm,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LANES-1:0]        mem_be,
    output logic [WORD_W-1:0]       mem_wdata,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic                    align_err,
    input  logic                    ld_valid,
    input  logic [2:0]              ld_kind,
    input  logic                    ld_unsigned,
    input  logic [OFF_W-1:0]        ld_off,
    input  logic [WORD_W-1:0]       ld_rdata,
    input  logic [WORD_W-1:0]       ld_old,
    output logic [WORD_W-1:0]       ld_result,
    output logic                    ld_done
);
    logic [ADDR_W-1:0] ea;
    logic              misaligned;
    logic              legal;
    logic [LANES-1:0]  be_c;
    logic [WORD_W-1:0] wdata_c;
    logic [WORD_W-1:0] result_c;
    logic              go;

    lsa_addr_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_addr (
        .base       (req_base),
        .imm        (req_imm),
        .kind       (req_kind),
        .ea         (ea),
        .misaligned (misaligned),
        .legal      (legal)
    );

    lsa_store_lane u_store (
        .kind  (req_kind),
        .off   (ea[OFF_W-1:0]),
        .src   (req_wdata),
        .be    (be_c),
        .wdata (wdata_c)
    );

    lsa_load_merge u_load (
        .kind     (ld_kind),
        .zero_ext (ld_unsigned),
        .off      (ld_off),
        .rdata    (ld_rdata),
        .old      (ld_old),
        .result   (result_c)
    );

    // A request goes to memory only if its kind is legal and aligned.
    always_comb begin
        go = req_valid & legal & ~misaligned;
    end

    // Request-side output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            align_err <= 1'b0;
        end else begin
            mem_we    <= go & req_store;
            mem_re    <= go & ~req_store;
            align_err <= req_valid & legal & misaligned;
            mem_be    <= go ? be_c : '0;
            if (req_valid) begin
                mem_addr  <= ea[ADDR_W-1:OFF_W];
                mem_wdata <= wdata_c;
            end
        end
    end

    // Load-side result register; holds its value between loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_result <= '0;
            ld_done   <= 1'b0;
        end else begin
            ld_done <= ld_valid;
            if (ld_valid) begin
                ld_result <= result_c;
            end
        end
    end
endmodule

// File: rtl/lsa_top_chk.sv
// Property checker for lsa_top, attached by bind. Observes ports only.
module lsa_top_chk
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_store,
    input logic [2:0]              req_kind,
    input logic [ADDR_W-1:0]       req_base,
    input logic [IMM_W-1:0]        req_imm,
    input logic [ADDR_W-OFF_W-1:0] mem_addr,
    input logic [LANES-1:0]        mem_be,
    input logic                    mem_we,
    input logic                    mem_re,
    input logic                    align_err,
    input logic                    ld_valid,
    input logic [2:0]              ld_kind,
    input logic [OFF_W-1:0]        ld_off,
    input logic [WORD_W-1:0]       ld_rdata,
    input logic [WORD_W-1:0]       ld_result,
    input logic                    ld_done
);
    logic [ADDR_W-1:0] ea_ref;
    assign ea_ref = req_base + {{(ADDR_W-IMM_W){req_imm[IMM_W-1]}}, req_imm};

    // R1
    addr_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_addr == $past(ea_ref[ADDR_W-1:OFF_W]));

    // R2
    byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(req_kind) == 3'd0) |-> $countones(mem_be) == 1);

    // R4
    word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(req_kind) == 3'd2) |-> mem_be == '1);

    // R8
    upper_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done && $past(ld_valid && ld_kind == 3'd3 && ld_off == '1))
            |-> ld_result == $past(ld_rdata));

    // R9
    misalign_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!mem_we && !mem_re && mem_be == '0));

    // R10
    write_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(req_valid && req_store));

    // R10
    read_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> $past(req_valid && !req_store));

    // R10
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> $past(ld_valid));
endmodule

bind lsa_top lsa_top_chk #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_kind  (req_kind),
    .req_base  (req_base),
    .req_imm   (req_imm),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .align_err (align_err),
    .ld_valid  (ld_valid),
    .ld_kind   (ld_kind),
    .ld_off    (ld_off),
    .ld_rdata  (ld_rdata),
    .ld_result (ld_result),
    .ld_done   (ld_done)
);

// File: tb/sim_lsa_top.sv
`timescale 1ns/1ps
module sim_lsa_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic        align_err;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_kind = '0;
    logic        ld_unsigned = 1'b0;
    logic [1:0]  ld_off = '0;
    logic [31:0] ld_rdata = '0;
    logic [31:0] ld_old = '0;
    logic [31:0] ld_result;
    logic        ld_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [31:0] last_result = '0;

    always #2 clk = ~clk;

    lsa_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_kind(req_kind),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .align_err(align_err),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_unsigned(ld_unsigned),
        .ld_off(ld_off), .ld_rdata(ld_rdata), .ld_old(ld_old),
        .ld_result(ld_result), .ld_done(ld_done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    function automatic string store_tag(input logic [2:0] k);
        case (k)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string load_tag(input logic [2:0] k);
        case (k)
            3'd0:    return "R6";
            3'd1:    return "R7";
            3'd2:    return "R11";
            3'd3:    return "R8";
            3'd4:    return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected mask and lane data, built byte by byte from R2..R5.
    function automatic logic [35:0] model_store(input logic [2:0] k, input int off,
                                                input logic [31:0] src);
        logic [3:0]  be = '0;
        logic [31:0] wd = '0;
        int h = off & 2;
        for (int j = 0; j < 4; j++) begin
            case (k)
                3'd0: if (j == off) begin be[j] = 1'b1; wd[8*j +: 8] = src[7:0]; end
                3'd1: if (j == h || j == h + 1) begin
                          be[j] = 1'b1; wd[8*j +: 8] = src[8*(j-h) +: 8];
                      end
                3'd2: begin be[j] = 1'b1; wd[8*j +: 8] = src[8*j +: 8]; end
                3'd3: if (j <= off) begin
                          be[j] = 1'b1; wd[8*j +: 8] = src[8*(j+3-off) +: 8];
                      end
                3'd4: if (j >= off) begin
                          be[j] = 1'b1; wd[8*j +: 8] = src[8*(j-off) +: 8];
                      end
                default: ;
            endcase
        end
        return {be, wd};
    endfunction

    // Expected register value after a load, from R6, R7, R8, R10, R11.
    function automatic logic [31:0] model_load(input logic [2:0] k, input bit uns,
                                               input int off, input logic [31:0] rd,
                                               input logic [31:0] old);
        logic [31:0] res = old;
        logic [7:0]  b;
        logic [15:0] hw;
        int h = off & 2;
        case (k)
            3'd0: begin
                b = rd[8*off +: 8];
                res = {{24{~uns & b[7]}}, b};
            end
            3'd1: begin
                hw = {rd[8*(h+1) +: 8], rd[8*h +: 8]};
                res = {{16{~uns & hw[15]}}, hw};
            end
            3'd2: res = rd;
            3'd3: for (int i = 0; i < 4; i++)
                      if (i >= 3 - off) res[8*i +: 8] = rd[8*(i-(3-off)) +: 8];
            3'd4: for (int i = 0; i < 4; i++)
                      if (i <= 3 - off) res[8*i +: 8] = rd[8*(i+off) +: 8];
            default: res = old;
        endcase
        return res;
    endfunction

    // One cycle of stimulus on both sides, then checks one clock later.
    task automatic run(input bit rv, input bit st, input logic [2:0] k,
                       input logic [31:0] base, input logic [15:0] imm,
                       input logic [31:0] src,
                       input bit lv, input logic [2:0] lk, input bit lu,
                       input logic [1:0] lo, input logic [31:0] rd,
                       input logic [31:0] old);
        logic [31:0] ea;
        bit legal, mis, go;
        logic [35:0] sm;
        logic [31:0] exp_ld;
        string t;
        req_valid = rv; req_store = st; req_kind = k; req_base = base;
        req_imm = imm; req_wdata = src;
        ld_valid = lv; ld_kind = lk; ld_unsigned = lu; ld_off = lo;
        ld_rdata = rd; ld_old = old;
        ea = base + {{16{imm[15]}}, imm};
        legal = (k <= 3'd4);
        mis = (k == 3'd1) ? ea[0] : (k == 3'd2) ? (ea[1:0] != 2'b00) : 1'b0;
        go = rv && legal && !mis;
        sm = model_store(k, int'(ea[1:0]), src);
        exp_ld = lv ? model_load(lk, lu, int'(lo), rd, old) : last_result;
        @(posedge clk);
        @(negedge clk);
        t = mis ? "R9" : "R10";
        if (rv) check("R1", "mem_addr", 32'(mem_addr), 32'(ea[31:2]));
        check(t, "mem_we", 32'(mem_we), 32'(go && st));
        check(t, "mem_re", 32'(mem_re), 32'(go && !st));
        check("R9", "align_err", 32'(align_err), 32'(rv && legal && mis));
        check(go ? store_tag(k) : t, "mem_be", 32'(mem_be), go ? 32'(sm[35:32]) : 32'd0);
        if (go && st) check(store_tag(k), "mem_wdata", mem_wdata, sm[31:0]);
        check("R11", "ld_done", 32'(ld_done), 32'(lv));
        check(lv ? load_tag(lk) : "R11", "ld_result", ld_result, exp_ld);
        last_result = exp_ld;
        req_valid = 1'b0;
        ld_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] b, s, rd, old;
        logic [15:0] im;
        logic [2:0]  k, lk;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10: reset state of every output.
        check("R10", "reset mem_we", 32'(mem_we), 32'd0);
        check("R10", "reset mem_re", 32'(mem_re), 32'd0);
        check("R10", "reset mem_be", 32'(mem_be), 32'd0);
        check("R10", "reset align_err", 32'(align_err), 32'd0);
        check("R10", "reset mem_addr", 32'(mem_addr), 32'd0);
        check("R10", "reset ld_done", 32'(ld_done), 32'd0);
        check("R10", "reset ld_result", ld_result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 byte store at offset 3, R6 signed / unsigned byte loads.
        run(1, 1, 3'd0, 32'h0000_1003, 16'h0000, 32'hAABB_CC80,
            1, 3'd0, 0, 2'd1, 32'h1122_8044, 32'h5555_5555);
        run(1, 0, 3'd0, 32'h0000_1000, 16'h0001, 32'h0,
            1, 3'd0, 1, 2'd1, 32'h1122_8044, 32'h5555_5555);
        // R3 halfword store at offset 2, R7 signed / unsigned half loads.
        run(1, 1, 3'd1, 32'h0000_2000, 16'h0002, 32'h1234_ABCD,
            1, 3'd1, 0, 2'd2, 32'h8001_7FFF, 32'h0);
        run(1, 1, 3'd1, 32'h0000_2000, 16'h0000, 32'h1234_ABCD,
            1, 3'd1, 1, 2'd2, 32'h8001_7FFF, 32'h0);
        // R4 word store, R11 word load.
        run(1, 1, 3'd2, 32'h0000_3000, 16'h0004, 32'hDEAD_BEEF,
            1, 3'd2, 0, 2'd0, 32'hCAFE_F00D, 32'h1);
        // R5 / R8 partial forms at every offset with distinct bytes.
        for (int o = 0; o < 4; o++) begin
            run(1, 1, 3'd3, 32'h0000_4000 + 32'(o), 16'h0, 32'h4433_2211,
                1, 3'd3, 0, 2'(o), 32'hDDCC_BBAA, 32'h8877_6655);
            run(1, 1, 3'd4, 32'h0000_4000 + 32'(o), 16'h0, 32'h4433_2211,
                1, 3'd4, 0, 2'(o), 32'hDDCC_BBAA, 32'h8877_6655);
        end
        // R1 negative offset wrapping below zero; R9 misaligned word.
        run(1, 1, 3'd2, 32'h0000_0002, 16'hFFFC, 32'h0F0F_0F0F,
            0, 3'd0, 0, 2'd0, 32'h0, 32'h0);
        run(1, 0, 3'd2, 32'h0000_0100, 16'hFFFC, 32'h0,
            0, 3'd0, 0, 2'd0, 32'h0, 32'h0);
        // R9 misaligned halfword load.
        run(1, 0, 3'd1, 32'h0000_0101, 16'h0000, 32'h0,
            0, 3'd0, 0, 2'd0, 32'h0, 32'h0);
        // R10 reserved kinds: no access, old value returned.
        run(1, 1, 3'd6, 32'h0000_5001, 16'h0000, 32'h1111_2222,
            1, 3'd7, 0, 2'd3, 32'hFFFF_FFFF, 32'h1357_9BDF);
        // R11 result holds while idle.
        run(0, 0, 3'd0, 32'h0, 16'h0, 32'h0,
            0, 3'd0, 0, 2'd0, 32'hFFFF_FFFF, 32'h0);

        for (int n = 0; n < 800; n++) begin
            k  = 3'($urandom % 5);
            lk = 3'($urandom % 5);
            b  = $urandom;
            im = 16'($urandom);
            s  = $urandom;
            rd = $urandom;
            old = $urandom;
            if ($urandom % 4 != 0) b = b - ((b + {{16{im[15]}}, im}) & 32'h3);
            if ($urandom % 16 == 0) k = 3'd5 + 3'($urandom % 3);
            run(($urandom % 8) != 0, 1'($urandom), k, b, im, s,
                ($urandom % 8) != 0, lk, 1'($urandom), 2'($urandom), rd, old);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule